// File: doc/BRIEF.md
# Hot-Swap Power Sequencing Controller

This block is the digital sequencer of a hot-swap switch that sits between a backplane supply and a load. Analog comparators outside the block report, one bit each, whether the internal supply is above its lockout level, whether the input is above its undervoltage level, whether it is above its overvoltage level, whether the pass transistor's drain has fallen close to the negative rail, and whether its gate is nearly fully enhanced. From these bits, two control pins (on and active-low enable), a power-good input from the downstream converter and an external fault pin, the block decides when the gate may be driven. It then drives a gate-enable level, a one-cycle fast-pulldown strobe, a latched power-good flag, an alert line and a sticky fault register.

Every delay is a multiple of one programmable cycle count, `dlyCycles`, which must be at least 1. A minimal write port reaches three words. Address 0 holds the FET-on control bit in data bit 3. Address 1 is the fault register, cleared by writing ones. Address 2 is the alert mask.

Top module: `hsc_top`

## Requirements
- R1: The gate is enabled only after `uvloOk`, `uvOk`, the FET-on bit and a low `enN` have held, with `ovHi` low, for `dlyCycles` consecutive cycles. If `ovHi` goes high, or any other one of these conditions is lost, the gate turns off at the next clock edge.
- R2: After reset, and after each recovery of `uvloOk`, the FET-on bit takes the level of `onPin` once `dlyCycles` cycles have passed. If `onPin` is low at that moment, the gate stays off until software sets the bit.
- R3: A rising edge on `onPin` sets the FET-on bit. A falling edge clears the FET-on bit and clears every fault bit.
- R4: While `enN` is high the gate is held off. Every transition of `enN` sets fault bit 3. A falling edge of `enN` first clears all fault bits (bit 3 is then set again) and loads the FET-on bit from `onPin`.
- R5: While the gate is on, `pwrGood` rises and stays latched once `gateHigh` and `drainLow` have both been true for `dlyCycles` consecutive cycles.
- R6: `pwrGood` is cleared by every gate turn-off, except a turn-off during which `ovHi` is high.
- R7: When `pwrGood` latches, a watchdog of 4×`dlyCycles` cycles starts. If `pgInN` is still high when the watchdog runs out, the gate turns off, fault bit 2 is set, and the gate stays off until bit 2 is cleared.
- R8: A low `extFaultN` sets fault bit 7 and has no effect on the gate.
- R9: Fault bits are sticky: bit 0 overvoltage, bit 1 undervoltage, bit 2 power bad, bit 3 enable change, bit 4 supply lockout, bit 7 external fault. Bits 5 and 6 read zero. Writing ones to address 1 clears the matching bits, and a set condition in the same cycle wins over the clear.
- R10: `alert` is high exactly when the fault register ANDed with the alert mask (address 2, reset value 0) is non-zero.
- R11: Loss of `uvloOk` turns the gate off at the next edge, clears `pwrGood`, sets fault bit 4 and restarts the power-up wait of R2.
- R12: `fastPull` is a one-cycle pulse. It is issued on every cycle in which a gate that was on is turned off.
- R13: A write to address 0 sets the FET-on bit to data bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dlyCycles | input | TMR_W | Start-up delay in cycles (at least 1) |
| uvloOk | input | 1 | Internal supply above lockout level |
| uvOk | input | 1 | Input supply above undervoltage level |
| ovHi | input | 1 | Input supply above overvoltage level |
| drainLow | input | 1 | Drain close to the negative rail |
| gateHigh | input | 1 | Gate near full enhancement |
| onPin | input | 1 | On control pin |
| enN | input | 1 | Active-low enable pin |
| pgInN | input | 1 | Power-good input from the load, active low |
| extFaultN | input | 1 | External fault pin, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 8 | Register write data |
| gateEn | output | 1 | Gate drive enable |
| fastPull | output | 1 | One-cycle fast pulldown strobe |
| pwrGood | output | 1 | Latched power-good flag |
| alert | output | 1 | Masked fault alert |
| faultReg | output | 8 | Sticky fault register |

## Verification
The hardest state to reach is the latched power-bad state. Getting there takes a full on sequence, a latched power-good, and then a complete 4×`dlyCycles` watchdog window with `pgInN` held high. The stimulus prepares this by first turning the gate off through software and raising `pgInN`. It then produces a fresh rising edge on `onPin` and waits through the start-up, power-good and watchdog windows, sampling before and after the expected expiry. It finally checks that the gate stays off until bit 2 is written clear. The interaction of the sticky fault bits with clears is covered by a seeded random phase: overvoltage, undervoltage, external-fault levels and writes arrive at random, and a per-cycle model of the register and the mask predicts each result.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  typedef enum logic [2:0] {
    S_INIT, S_OFF, S_START, S_ON, S_PG, S_RUN, S_BAD
  } hscState_t;

  typedef struct packed {
    logic cntClr;
    logic loadFetOn;
    logic logPwrBad;
  } hscStrobe_t;

  localparam int FB_OV   = 0;
  localparam int FB_UV   = 1;
  localparam int FB_PBAD = 2;
  localparam int FB_EN   = 3;
  localparam int FB_UVLO = 4;
  localparam int FB_EXT  = 7;

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_FAULT = 2'd1;
  localparam logic [1:0] A_MASK  = 2'd2;
  localparam int CTRL_FET_BIT = 3;
endpackage

// File: rtl/hsc_datapath.sv
module hsc_datapath
  import hsc_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TMR_W-1:0] dlyCycles,
  input  hscStrobe_t       stb,
  input  logic             uvloOk,
  input  logic             uvOk,
  input  logic             ovHi,
  input  logic             onPin,
  input  logic             enN,
  input  logic             extFaultN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [7:0]       wrData,
  output logic             fetOn,
  output logic             startDone,
  output logic             wdDone,
  output logic [7:0]       faultReg,
  output logic             alert
);
  localparam int CW = TMR_W + 2;

  logic [CW-1:0] cnt, dlyEnd, wdEnd;
  logic onQ, enQ, primed;
  logic onRise, onFall, enRise, enFall;
  logic [7:0] setV, clrV, alertMask;

  assign dlyEnd = CW'(dlyCycles) - CW'(1);
  assign wdEnd  = {dlyCycles, 2'b00} - CW'(1);
  assign startDone = (cnt == dlyEnd);
  assign wdDone    = (cnt == wdEnd);

  // shared delay counter, saturating
  always_ff @(posedge clk) begin
    if (!rstN)               cnt <= '0;
    else if (stb.cntClr)     cnt <= '0;
    else if (cnt != {CW{1'b1}}) cnt <= cnt + CW'(1);
  end

  // pin edge detection, qualified one cycle after reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      onQ <= 1'b0; enQ <= 1'b0; primed <= 1'b0;
    end else begin
      onQ <= onPin; enQ <= enN; primed <= 1'b1;
    end
  end

  assign onRise = primed & onPin & ~onQ;
  assign onFall = primed & ~onPin & onQ;
  assign enRise = primed & enN & ~enQ;
  assign enFall = primed & ~enN & enQ;

  // FET-on control bit
  always_ff @(posedge clk) begin
    if (!rstN)                fetOn <= 1'b0;
    else if (stb.loadFetOn)   fetOn <= onPin;
    else if (enFall)          fetOn <= onPin;
    else if (onRise)          fetOn <= 1'b1;
    else if (onFall)          fetOn <= 1'b0;
    else if (wrEn && wrAddr == A_CTRL) fetOn <= wrData[CTRL_FET_BIT];
  end

  // sticky fault register, set wins over clear
  always_comb begin
    setV = '0;
    setV[FB_OV]   = ovHi;
    setV[FB_UV]   = ~uvOk;
    setV[FB_PBAD] = stb.logPwrBad;
    setV[FB_EN]   = enRise | enFall;
    setV[FB_UVLO] = ~uvloOk;
    setV[FB_EXT]  = ~extFaultN;
    clrV = ((onFall | enFall) ? 8'hFF : 8'h00) |
           ((wrEn && wrAddr == A_FAULT) ? wrData : 8'h00);
  end

  always_ff @(posedge clk) begin
    if (!rstN) faultReg <= '0;
    else       faultReg <= (faultReg & ~clrV) | setV;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                          alertMask <= '0;
    else if (wrEn && wrAddr == A_MASK)  alertMask <= wrData;
  end

  assign alert = |(faultReg & alertMask);

  AST_EXT_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    !extFaultN |=> faultReg[FB_EXT]); // R8
  AST_OV_LOGGED: assert property (@(posedge clk) disable iff (!rstN)
    ovHi |=> faultReg[FB_OV]); // R9
endmodule

// File: rtl/hsc_ctrl.sv
module hsc_ctrl
  import hsc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       uvloOk,
  input  logic       uvOk,
  input  logic       ovHi,
  input  logic       enN,
  input  logic       drainLow,
  input  logic       gateHigh,
  input  logic       pgInN,
  input  logic       fetOn,
  input  logic       startDone,
  input  logic       wdDone,
  input  logic       pwrBadBit,
  output hscStrobe_t stb,
  output logic       gateEn,
  output logic       fastPull,
  output logic       pwrGood
);
  hscState_t state, nextState;
  logic runOk, gateOnNow, pulse, pgSet, pgClr;

  assign runOk     = uvOk & ~ovHi & ~enN & fetOn;
  assign gateOnNow = (state == S_ON) || (state == S_PG) || (state == S_RUN);
  assign gateEn    = gateOnNow;

  always_comb begin
    nextState = state;
    stb   = '0;
    pulse = 1'b0;
    pgSet = 1'b0;
    pgClr = 1'b0;
    if (!uvloOk) begin
      nextState  = S_INIT;
      stb.cntClr = 1'b1;
      pulse      = gateOnNow;
      pgClr      = 1'b1;
    end else if (gateOnNow && !runOk) begin
      nextState  = S_OFF;
      stb.cntClr = 1'b1;
      pulse      = 1'b1;
      pgClr      = ~ovHi;
    end else begin
      case (state)
        S_INIT: if (startDone) begin
          nextState = S_OFF; stb.cntClr = 1'b1; stb.loadFetOn = 1'b1;
        end
        S_OFF: if (runOk) begin
          nextState = S_START; stb.cntClr = 1'b1;
        end
        S_START: begin
          if (!runOk) begin
            nextState = S_OFF; stb.cntClr = 1'b1;
          end else if (startDone) begin
            nextState = S_ON; stb.cntClr = 1'b1;
          end
        end
        S_ON: begin
          if (!(gateHigh && drainLow)) stb.cntClr = 1'b1;
          else if (startDone) begin
            nextState = S_PG; stb.cntClr = 1'b1; pgSet = 1'b1;
          end
        end
        S_PG: begin
          if (!pgInN) nextState = S_RUN;
          else if (wdDone) begin
            nextState = S_BAD; stb.cntClr = 1'b1; stb.logPwrBad = 1'b1;
            pulse = 1'b1; pgClr = 1'b1;
          end
        end
        S_RUN: nextState = S_RUN;
        S_BAD: if (!pwrBadBit) begin
          nextState = S_OFF; stb.cntClr = 1'b1;
        end
        default: nextState = S_INIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_INIT; fastPull <= 1'b0; pwrGood <= 1'b0;
    end else begin
      state    <= nextState;
      fastPull <= pulse;
      if (pgClr)      pwrGood <= 1'b0;
      else if (pgSet) pwrGood <= 1'b1;
    end
  end

  AST_UVLO_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !uvloOk |=> !gateEn); // R11
  AST_OV_OFF: assert property (@(posedge clk) disable iff (!rstN)
    ovHi |=> !gateEn); // R1
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    fastPull |=> !fastPull); // R12
  AST_PG_OV_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (pwrGood && ovHi && uvloOk) |=> pwrGood); // R6
  AST_BAD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BAD && pwrBadBit) |=> !gateEn); // R7
endmodule

// File: rtl/hsc_top.sv
module hsc_top
  import hsc_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TMR_W-1:0] dlyCycles,
  input  logic             uvloOk,
  input  logic             uvOk,
  input  logic             ovHi,
  input  logic             drainLow,
  input  logic             gateHigh,
  input  logic             onPin,
  input  logic             enN,
  input  logic             pgInN,
  input  logic             extFaultN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [7:0]       wrData,
  output logic             gateEn,
  output logic             fastPull,
  output logic             pwrGood,
  output logic             alert,
  output logic [7:0]       faultReg
);
  hscStrobe_t stb;
  logic fetOn, startDone, wdDone;

  hsc_datapath #(.TMR_W(TMR_W)) uData (
    .clk(clk), .rstN(rstN), .dlyCycles(dlyCycles), .stb(stb),
    .uvloOk(uvloOk), .uvOk(uvOk), .ovHi(ovHi), .onPin(onPin), .enN(enN),
    .extFaultN(extFaultN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .fetOn(fetOn), .startDone(startDone), .wdDone(wdDone),
    .faultReg(faultReg), .alert(alert)
  );

  hsc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .uvloOk(uvloOk), .uvOk(uvOk), .ovHi(ovHi),
    .enN(enN), .drainLow(drainLow), .gateHigh(gateHigh), .pgInN(pgInN),
    .fetOn(fetOn), .startDone(startDone), .wdDone(wdDone),
    .pwrBadBit(faultReg[FB_PBAD]), .stb(stb), .gateEn(gateEn),
    .fastPull(fastPull), .pwrGood(pwrGood)
  );
endmodule

// File: tb/tb_hsc_top.sv
module tb_hsc_top;
  logic clk = 1'b0;
  logic rstN;
  logic [15:0] dlyCycles;
  logic uvloOk, uvOk, ovHi, drainLow, gateHigh, onPin, enN, pgInN, extFaultN;
  logic wrEn;
  logic [1:0] wrAddr;
  logic [7:0] wrData;
  logic gateEn, fastPull, pwrGood, alert;
  logic [7:0] faultReg;

  int errors = 0;
  int checks = 0;
  int pulseCnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hsc_top dut (
    .clk(clk), .rstN(rstN), .dlyCycles(dlyCycles), .uvloOk(uvloOk), .uvOk(uvOk),
    .ovHi(ovHi), .drainLow(drainLow), .gateHigh(gateHigh), .onPin(onPin),
    .enN(enN), .pgInN(pgInN), .extFaultN(extFaultN), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .gateEn(gateEn), .fastPull(fastPull),
    .pwrGood(pwrGood), .alert(alert), .faultReg(faultReg)
  );

  always @(negedge clk) if (rstN && fastPull) pulseCnt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic [7:0] faultSet(input logic ov, input logic uvOkV, input logic extN);
    logic [7:0] s = 8'h00;
    s[0] = ov; s[1] = ~uvOkV; s[7] = ~extN;
    return s;
  endfunction

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog timeout actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] expF, expM;
    int pc0;
    void'($urandom(32'h5EED));
    rstN = 1'b0; dlyCycles = 16'd5;
    uvloOk = 1; uvOk = 1; ovHi = 0; drainLow = 0; gateHigh = 0;
    onPin = 1; enN = 0; pgInN = 0; extFaultN = 1;
    wrEn = 0; wrAddr = 0; wrData = 0;
    tick(3);
    chk("R9 reset fault", faultReg, 0);
    chk("R12 reset pulse", fastPull, 0);
    chk("R10 reset alert", alert, 0);
    chk("R1 reset gate", gateEn, 0);
    rstN = 1'b1;
    // R2/R1: power-up with on high
    tick(8);  chk("R1 gate off during delays", gateEn, 0);
    tick(17); chk("R2 auto on after power-up", gateEn, 1);
    // R5 power good
    gateHigh = 1; drainLow = 1;
    tick(2);  chk("R5 pg not yet", pwrGood, 0);
    tick(10); chk("R5 pg latched", pwrGood, 1);
    tick(40); chk("R7 watchdog satisfied", gateEn, 1);
    chk("R9 no faults", faultReg, 0);
    // R6 overvoltage turn-off keeps power good
    pc0 = pulseCnt;
    ovHi = 1; tick(2);
    chk("R1 ov turns off", gateEn, 0);
    chk("R6 pg kept on ov", pwrGood, 1);
    chk("R9 ov bit", faultReg[0], 1);
    chk("R12 one pulse on ov", pulseCnt - pc0, 1);
    ovHi = 0; tick(15);
    chk("R1 restart after ov", gateEn, 1);
    // R3 falling on
    onPin = 0; tick(3);
    chk("R3 on fall off", gateEn, 0);
    chk("R6 pg cleared", pwrGood, 0);
    chk("R3 on fall clears faults", faultReg, 0);
    chk("R12 pulse count", pulseCnt - pc0, 2);
    tick(20); chk("R3 stays off", gateEn, 0);
    // R13 software on
    wr(2'd0, 8'h08);
    tick(3);  chk("R13 delay running", gateEn, 0);
    tick(12); chk("R13 software on", gateEn, 1);
    // R7 watchdog expiry
    pgInN = 1;
    wr(2'd0, 8'h00); tick(2);
    chk("R13 software off", gateEn, 0);
    onPin = 1;
    tick(13); chk("R3 on rise turns on", gateEn, 1);
    tick(10); chk("R5 pg in window", pwrGood, 1);
    chk("R7 gate in window", gateEn, 1);
    tick(20); chk("R7 expiry off", gateEn, 0);
    chk("R7 power bad bit", faultReg[2], 1);
    chk("R6 pg cleared on bad", pwrGood, 0);
    tick(30); chk("R7 held off", gateEn, 0);
    pgInN = 0;
    wr(2'd1, 8'h04);
    tick(14); chk("R7 release after clear", gateEn, 1);
    // R4 enable
    enN = 1; tick(2);
    chk("R4 enable high off", gateEn, 0);
    chk("R4 enable change bit", faultReg[3], 1);
    extFaultN = 0; tick(1); extFaultN = 1; tick(1);
    chk("R8 ext bit", faultReg[7], 1);
    enN = 0; tick(2);
    chk("R4 enable fall clears", faultReg, 8'h08);
    tick(14); chk("R4 enable fall loads on", gateEn, 1);
    // R8 / R10
    extFaultN = 0; tick(2); extFaultN = 1; tick(1);
    chk("R8 gate unaffected", gateEn, 1);
    chk("R8 ext latched", faultReg[7], 1);
    wr(2'd2, 8'h80); chk("R10 alert on", alert, 1);
    wr(2'd2, 8'h01); chk("R10 alert masked", alert, 0);
    wr(2'd2, 8'h08); chk("R10 alert en bit", alert, 1);
    // R11 supply lockout
    pc0 = pulseCnt;
    uvloOk = 0; tick(2);
    chk("R11 uvlo off", gateEn, 0);
    chk("R11 pg cleared", pwrGood, 0);
    chk("R11 uvlo bit", faultReg[4], 1);
    chk("R12 uvlo pulse", pulseCnt - pc0, 1);
    onPin = 0; tick(2);
    uvloOk = 1;
    tick(30); chk("R2 on low stays off", gateEn, 0);
    wr(2'd0, 8'h08);
    tick(14); chk("R2 software after power-up", gateEn, 1);
    // R9/R10 random sticky register phase
    enN = 1; tick(2);
    wr(2'd1, 8'hFF); wr(2'd2, 8'h00);
    expF = 8'h00; expM = 8'h00;
    chk("R9 cleared by write", faultReg, 0);
    for (int i = 0; i < 300; i++) begin
      logic [7:0] clr;
      ovHi      = ($urandom % 8) == 0;
      uvOk      = ($urandom % 8) != 0;
      extFaultN = ($urandom % 8) != 0;
      wrEn      = ($urandom % 4) == 0;
      wrAddr    = ($urandom % 2) ? 2'd1 : 2'd2;
      wrData    = 8'($urandom);
      clr = (wrEn && wrAddr == 2'd1) ? wrData : 8'h00;
      if (wrEn && wrAddr == 2'd2) expM = wrData;
      expF = (expF & ~clr) | faultSet(ovHi, uvOk, extFaultN);
      @(negedge clk);
      chk("R9 random fault reg", faultReg, expF);
      chk("R10 random alert", alert, |(expF & expM));
    end
    wrEn = 0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule